// File: doc/BRIEF.md
# VGA Legacy Register File

This block models the byte-wide I/O register set of a standard VGA adapter in the port window 0x3C0 to 0x3DA. It holds the attribute controller, the sequencer, the graphics controller, the CRTC, the miscellaneous output register, the colour palette with its two byte pointers, and the input status byte. It also models the side effects that reads and writes have on that state. It does not generate video timing, and it has no memory-plane or pixel path.

A host drives a simple synchronous port bus into the block: a port address, write data, a write strobe, a read strobe and a wide-write flag. Read data is registered. Ports outside the window are ignored on write and read back as 0xFF.

Top module: `vga_regfile`

## Requirements
- R1: Synchronous reset clears the attribute toggle, every index register, both palette pointers, the miscellaneous output register and the status byte to 0. After reset, a read of 0x3CC returns 0x00, a read of 0x3DA returns 0x00, and a read of 0x3C0 returns attribute index 0x00.
- R2: Port 0x3C0 holds a toggle. At toggle 0 a read or write reaches the attribute index. At toggle 1 it reaches the attribute entry that the index selects. Every read or write of 0x3C0 inverts the toggle.
- R3: A read of 0x3C1 returns the attribute entry at the current index and leaves the toggle unchanged.
- R4: A read of 0x3DA returns the status byte and forces the toggle to 0. After the read, the status byte is XORed with 0x09.
- R5: A write to 0x3C2 sets the miscellaneous output register, and a read of 0x3CC returns it.
- R6: Ports 0x3D4 (CRTC index) and 0x3D5 (CRTC data) work only while bit 0 of the miscellaneous output register is 1. While it is 0, reads of them return 0xFF and writes to them change nothing.
- R7: A write of value v to 0x3C7 sets the palette read pointer to 3*v. A write of v to 0x3C8 sets the palette write pointer to 3*v.
- R8: A read of 0x3C9 returns the palette byte at the read pointer and then advances that pointer. A write of 0x3C9 stores the byte at the write pointer and then advances that pointer. Once a pointer reaches 768, further reads of 0x3C9 return 0xFF and further writes are dropped.
- R9: A data write whose index is at or past its array size (21 attribute, 5 sequencer, 9 graphics, 25 CRTC entries) is dropped, and the matching read returns 0xFF. Every other port, inside or outside the window, reads 0xFF.
- R10: A write with the wide flag set writes wdata[7:0] to the addressed port in that cycle. It then writes wdata[15:8] to the next port in the following cycle.
- R11: Ports 0x3C4 and 0x3CE read back the sequencer index and the graphics index. Ports 0x3C5 and 0x3CF store and return the entry that their index selects.
- R12: rdata takes the read result on the clock edge that samples rd_en, and read side effects take effect on that same edge. rdata holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Port address |
| wdata | input | 16 | Write data; only bits 7:0 are used unless the write is wide |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | Marks the write as 16-bit |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
The assertions rely on three things about the host. It never raises rd_en and wr_en in the same cycle. It leaves the bus idle in the cycle after a wide write, while the high byte is being written. It never reads a storage entry that it has not written first.

The stimulus follows these rules by construction. Every access is a single-cycle task followed by at least one idle edge, and every table sequence writes an entry before it reads it back.

// File: rtl/vga_regfile.sv
module vga_regfile #(
  parameter int AW    = 16,
  parameter int ATT_N = 21,
  parameter int SEQ_N = 5,
  parameter int GFX_N = 9,
  parameter int CRT_N = 25,
  parameter int PAL_N = 768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic          rd_en,
  output logic [7:0]    rdata
);
  localparam int PW  = $clog2(PAL_N + 1);
  localparam int AIW = $clog2(ATT_N);
  localparam int SIW = $clog2(SEQ_N);
  localparam int GIW = $clog2(GFX_N);
  localparam int CIW = $clog2(CRT_N);
  localparam logic [7:0] NONE = 8'hFF;
  localparam logic [AW-1:0] P_ATT = AW'('h3C0), P_ATR = AW'('h3C1), P_MSW = AW'('h3C2),
    P_SQI = AW'('h3C4), P_SQD = AW'('h3C5), P_PRP = AW'('h3C7), P_PWP = AW'('h3C8),
    P_PAL = AW'('h3C9), P_MSR = AW'('h3CC), P_GRI = AW'('h3CE), P_GRD = AW'('h3CF),
    P_CRI = AW'('h3D4), P_CRD = AW'('h3D5), P_STS = AW'('h3DA);

  logic [7:0] att_m [ATT_N];
  logic [7:0] seq_m [SEQ_N];
  logic [7:0] gfx_m [GFX_N];
  logic [7:0] crt_m [CRT_N];
  logic [7:0] pal_m [PAL_N];
  logic          toggle;
  logic [7:0]    att_idx, seq_idx, gfx_idx, crt_idx, misc, status;
  logic [PW-1:0] pal_rp, pal_wp;
  logic          hi_pend;
  logic [AW-1:0] hi_addr;
  logic [7:0]    hi_data;

  wire          do_wr  = wr_en | hi_pend;
  wire [AW-1:0] wa     = hi_pend ? hi_addr : addr;
  wire [7:0]    wd     = hi_pend ? hi_data : wdata[7:0];
  wire          do_rd  = rd_en & ~do_wr;
  wire          crt_on = misc[0];
  wire [PW-1:0] x3     = PW'({wd, 1'b0}) + PW'(wd);
  wire          att_ok = att_idx < 8'(ATT_N);
  wire          seq_ok = seq_idx < 8'(SEQ_N);
  wire          gfx_ok = gfx_idx < 8'(GFX_N);
  wire          crt_ok = crt_idx < 8'(CRT_N);
  wire          rp_ok  = pal_rp < PW'(PAL_N);
  wire          wp_ok  = pal_wp < PW'(PAL_N);
  wire [7:0]    att_q  = att_ok ? att_m[AIW'(att_idx)] : NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle  <= 1'b0;
      att_idx <= '0; seq_idx <= '0; gfx_idx <= '0; crt_idx <= '0;
      misc    <= '0; status  <= '0;
      pal_rp  <= '0; pal_wp  <= '0;
      hi_pend <= 1'b0; hi_addr <= '0; hi_data <= '0;
      rdata   <= '0;
    end else begin
      hi_pend <= wr_en & wr_wide & ~hi_pend;
      hi_addr <= addr + AW'(1);
      hi_data <= wdata[15:8];
      if (do_wr) begin
        unique case (wa)
          P_ATT: begin
            if (!toggle) att_idx <= wd;
            else if (att_ok) att_m[AIW'(att_idx)] <= wd;
            toggle <= ~toggle;
          end
          P_MSW: misc <= wd;
          P_SQI: seq_idx <= wd;
          P_SQD: if (seq_ok) seq_m[SIW'(seq_idx)] <= wd;
          P_PRP: pal_rp <= x3;
          P_PWP: pal_wp <= x3;
          P_PAL: if (wp_ok) begin pal_m[pal_wp] <= wd; pal_wp <= pal_wp + PW'(1); end
          P_GRI: gfx_idx <= wd;
          P_GRD: if (gfx_ok) gfx_m[GIW'(gfx_idx)] <= wd;
          P_CRI: if (crt_on) crt_idx <= wd;
          P_CRD: if (crt_on && crt_ok) crt_m[CIW'(crt_idx)] <= wd;
          default: ;
        endcase
      end else if (do_rd) begin
        rdata <= NONE;
        unique case (addr)
          P_ATT: begin rdata <= toggle ? att_q : att_idx; toggle <= ~toggle; end
          P_ATR: rdata <= att_q;
          P_MSR: rdata <= misc;
          P_SQI: rdata <= seq_idx;
          P_SQD: if (seq_ok) rdata <= seq_m[SIW'(seq_idx)];
          P_PAL: if (rp_ok) begin rdata <= pal_m[pal_rp]; pal_rp <= pal_rp + PW'(1); end
          P_GRI: rdata <= gfx_idx;
          P_GRD: if (gfx_ok) rdata <= gfx_m[GIW'(gfx_idx)];
          P_CRI: if (crt_on) rdata <= crt_idx;
          P_CRD: if (crt_on && crt_ok) rdata <= crt_m[CIW'(crt_idx)];
          P_STS: begin rdata <= status; status <= status ^ 8'h09; toggle <= 1'b0; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vga_regfile_chk.sv
module vga_regfile_chk #(
  parameter int AW = 16,
  parameter int PW = 10,
  parameter int PAL_N = 768
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr,
  input logic [7:0]    wlo,
  input logic          wr_en,
  input logic          wr_wide,
  input logic          rd_en,
  input logic          hi_pend,
  input logic          toggle,
  input logic [7:0]    status,
  input logic [7:0]    misc,
  input logic [7:0]    crt_idx,
  input logic [PW-1:0] pal_rp,
  input logic [PW-1:0] pal_wp
);
  wire rd_ok = rd_en && !wr_en && !hi_pend;
  wire wr_ok = wr_en && !hi_pend;

  // R4
  status_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && addr == AW'('h3DA)) |=> (!toggle && status == ($past(status) ^ 8'h09)));
  // R2
  att_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_ok || wr_ok) && addr == AW'('h3C0)) |=> (toggle != $past(toggle)));
  // R3
  att_peek_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && addr == AW'('h3C1)) |=> $stable(toggle));
  // R6
  crt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && addr == AW'('h3D4) && !misc[0]) |=> $stable(crt_idx));
  // R7
  rp_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && addr == AW'('h3C7)) |=> (pal_rp == PW'(3 * $past(wlo))));
  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (pal_rp <= PW'(PAL_N) && pal_wp <= PW'(PAL_N)));
  // R10
  wide_split_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && wr_wide) |=> hi_pend);
endmodule

bind vga_regfile vga_regfile_chk #(.AW(AW), .PW(PW), .PAL_N(PAL_N)) chk (
  .clk(clk), .rst(rst), .addr(addr), .wlo(wdata[7:0]), .wr_en(wr_en), .wr_wide(wr_wide),
  .rd_en(rd_en), .hi_pend(hi_pend), .toggle(toggle), .status(status), .misc(misc),
  .crt_idx(crt_idx), .pal_rp(pal_rp), .pal_wp(pal_wp));

// File: tb/tb_vga_regfile.sv
module tb_vga_regfile;
  logic clk = 0, rst = 1;
  logic [15:0] addr = '0, wdata = '0;
  logic wr_en = 0, wr_wide = 0, rd_en = 0;
  logic [7:0] rdata;
  int n_chk = 0, n_bad = 0;

  vga_regfile dut (.clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .wr_wide(wr_wide), .rd_en(rd_en), .rdata(rdata));

  always #5 clk = ~clk;

  // op: 0 write, 1 read and check, 2 read without check
  localparam int NV = 44;
  localparam logic [33:0] VEC [NV] = '{
    {2'd0,16'h3C2,8'h01,8'h00}, {2'd1,16'h3CC,8'h00,8'h01},                               // R5
    {2'd0,16'h3C4,8'h02,8'h00}, {2'd0,16'h3C5,8'h5A,8'h00},
    {2'd1,16'h3C4,8'h00,8'h02}, {2'd1,16'h3C5,8'h00,8'h5A},                               // R11
    {2'd0,16'h3CE,8'h08,8'h00}, {2'd0,16'h3CF,8'hC3,8'h00},
    {2'd1,16'h3CE,8'h00,8'h08}, {2'd1,16'h3CF,8'h00,8'hC3},                               // R11
    {2'd0,16'h3D4,8'h18,8'h00}, {2'd0,16'h3D5,8'h77,8'h00},
    {2'd1,16'h3D4,8'h00,8'h18}, {2'd1,16'h3D5,8'h00,8'h77},                               // R6
    {2'd2,16'h3DA,8'h00,8'h00},
    {2'd0,16'h3C0,8'h10,8'h00}, {2'd0,16'h3C0,8'hAB,8'h00},
    {2'd1,16'h3C0,8'h00,8'h10}, {2'd1,16'h3C0,8'h00,8'hAB},                               // R2
    {2'd1,16'h3C1,8'h00,8'hAB}, {2'd1,16'h3C1,8'h00,8'hAB}, {2'd1,16'h3C0,8'h00,8'h10},   // R3
    {2'd2,16'h3DA,8'h00,8'h00},
    {2'd0,16'h3C0,8'h15,8'h00}, {2'd0,16'h3C0,8'h55,8'h00},
    {2'd1,16'h3C0,8'h00,8'h15}, {2'd1,16'h3C0,8'h00,8'hFF},                               // R9
    {2'd0,16'h3C4,8'h05,8'h00}, {2'd0,16'h3C5,8'h11,8'h00}, {2'd1,16'h3C5,8'h00,8'hFF},   // R9
    {2'd1,16'h3C6,8'h00,8'hFF}, {2'd1,16'h3B0,8'h00,8'hFF},                               // R9
    {2'd0,16'h3C4,8'h02,8'h00}, {2'd1,16'h3C5,8'h00,8'h5A},
    {2'd0,16'h3C8,8'h01,8'h00}, {2'd0,16'h3C9,8'h11,8'h00}, {2'd0,16'h3C9,8'h22,8'h00},
    {2'd0,16'h3C9,8'h33,8'h00}, {2'd0,16'h3C7,8'h01,8'h00},
    {2'd1,16'h3C9,8'h00,8'h11}, {2'd1,16'h3C9,8'h00,8'h22}, {2'd1,16'h3C9,8'h00,8'h33},   // R7 R8
    {2'd0,16'h3C8,8'h00,8'h00}, {2'd0,16'h3C9,8'h44,8'h00}
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic wide = 0);
    @(negedge clk); addr = a; wdata = d; wr_en = 1; wr_wide = wide;
    @(negedge clk); wr_en = 0; wr_wide = 0;
    if (wide) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic rdc(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    rdc("R1 misc", 16'h3CC, 8'h00);
    rdc("R1 att idx", 16'h3C0, 8'h00);
    rdc("R4 status0", 16'h3DA, 8'h00);
    rdc("R4 status1", 16'h3DA, 8'h09);
    rdc("R4 status2", 16'h3DA, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33:32] == 2'd0) wr(VEC[i][31:16], {8'h00, VEC[i][15:8]});
      else if (VEC[i][33:32] == 2'd2) rd(VEC[i][31:16], v);
      else rdc($sformatf("vec%0d", i), VEC[i][31:16], VEC[i][7:0]);
    end

    // R8 palette end: pointer 765, fourth byte dropped
    wr(16'h3C8, 16'h00FF);
    wr(16'h3C9, 16'h00A1); wr(16'h3C9, 16'h00A2); wr(16'h3C9, 16'h00A3); wr(16'h3C9, 16'h00A4);
    wr(16'h3C7, 16'h00FF);
    rdc("R8 pal765", 16'h3C9, 8'hA1);
    rdc("R8 pal766", 16'h3C9, 8'hA2);
    rdc("R8 pal767", 16'h3C9, 8'hA3);
    rdc("R8 past end", 16'h3C9, 8'hFF);
    wr(16'h3C7, 16'h0000);
    rdc("R8 no wrap", 16'h3C9, 8'h44);

    // R6 CRTC gated off
    wr(16'h3C2, 16'h0000);
    rdc("R6 idx off", 16'h3D4, 8'hFF);
    rdc("R6 data off", 16'h3D5, 8'hFF);
    wr(16'h3D4, 16'h0003); wr(16'h3D5, 16'h0099);
    wr(16'h3C2, 16'h0001);
    rdc("R6 idx kept", 16'h3D4, 8'h18);
    rdc("R6 data kept", 16'h3D5, 8'h77);

    // R10 wide write to index/data pair
    wr(16'h3C4, 16'h3C01, 1'b1);
    rdc("R10 lo byte", 16'h3C4, 8'h01);
    rdc("R10 hi byte", 16'h3C5, 8'h3C);

    // R12 registered read and hold
    @(negedge clk); addr = 16'h3CC; rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
    check("R12 same edge", rdata, 8'h01);
    @(negedge clk); addr = 16'h3C4;
    @(negedge clk);
    check("R12 hold", rdata, 8'h01);

    // R1 reset mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    rdc("R1 misc again", 16'h3CC, 8'h00);
    rdc("R1 seq idx", 16'h3C4, 8'h00);
    rdc("R1 att toggle", 16'h3C0, 8'h00);
    rdc("R1 status", 16'h3DA, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule